// File: doc/BRIEF.md
# Multidrop Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port for a shared multidrop line. A host reaches it through a small register interface. Through that interface the host writes characters to send and reads characters that have arrived. It also programs the bit-rate divisor, the character format, its own station address and an interrupt mask, and it reads and clears the line status. Each direction has a holding register in front of its shift register. The host can therefore queue one character while another is on the wire, and one received character can wait while the next one arrives.

A character on the wire is laid out as follows: a low start bit, 5 to 8 data bits sent least significant bit first, an optional ninth bit, an optional parity bit, and one or two high stop bits. The ninth bit exists only in multidrop mode, where it marks a frame as an address. In that mode an address frame that matches the station address opens delivery of the data frames that follow it. Any other address closes delivery. Data frames that arrive while delivery is closed are dropped. A bit lasts 16 clock periods times the divisor, and a divisor of 0 counts as 65536. The bit rate therefore spans from the clock divided by 16 down to the clock divided by 1,048,576.

Register map (3-bit `addr`). Address 0: a write queues a character, with the ninth bit in wrData[8]; a read returns the oldest received character and frees the receive holding register. Address 1: divisor. Address 2: line format. Address 3: station address. Address 4: interrupt mask. Address 5: status, and writing 1s to it clears error flags.

Top module: `mdrop_uart`

## Requirements
- R1: After reset `txOut` is high, the status register (address 5) reads 0x0003 (bit0 transmit holding empty, bit1 transmitter idle, everything else clear) and all interrupt outputs are low.
- R2: With divisor value D (address 1, D from 1 to 65535, 0 meaning 65536), every transmitted bit, the start bit included, lasts exactly 16·D clock cycles.
- R3: A transmitted character is a low start bit, then (line[1:0]+5) data bits least significant first, then wrData[8] when line[5] is set, then a parity bit when enabled, then one high stop bit, or two when line[2] is set. Data bits above the configured length are not sent. The line is high whenever the transmitter is idle.
- R4: Parity mode is line[4:3]: 01 even, 10 odd, 00 or 11 none. Even parity makes the count of ones over the data bits plus the parity bit even. Odd parity makes that count odd.
- R5: A character written while the transmit shifter is busy waits in the holding register and is sent directly after the current character. A write made while the holding register is full is ignored.
- R6: A received character in the configured format is placed right-aligned in the receive holding register and sets status bit2. A read of address 0 returns it and clears bit2.
- R7: A low pulse on `rxIn` that has ended before the middle of the start bit produces no character.
- R8: Status bit4 (framing) is set when the first stop bit samples low. Status bit3 (parity) is set when the received parity bit disagrees with the configured parity.
- R9: When a character completes while the receive holding register is full, status bit5 (overrun) is set, the new character is dropped and the held character is kept.
- R10: With line[5] set, a received frame whose ninth bit is 1 is not delivered. Its data is compared with the station address (address 3): a match sets status bit6 and enables delivery, and a mismatch clears both. Frames whose ninth bit is 0 are delivered only while delivery is enabled.
- R11: `irqTx` = mask[0] AND transmit holding empty, `irqRx` = mask[1] AND receive full, `irqErr` = mask[2] AND any of status bits 3 to 5. Writing a 1 to one of status bits 3 to 5 clears that flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of address 0 pops the receive holding register) |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, combinational from `addr` |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| irqTx | output | 1 | Transmit-ready interrupt |
| irqRx | output | 1 | Receive-ready interrupt |
| irqErr | output | 1 | Line error interrupt |

## Verification
The bench measures the start bit to the clock. A bit-timer that is off by one divisor period, or one that counts the 16x ticks wrongly, changes that count. It sends a third character while the holding register is full and a correctly built port drops it. A design that overwrote the holding register would send the wrong second character, and one that queued it would send an extra frame. On the receive side the bench drives a short low glitch, a stop bit held low, two characters with no read between them, and a sequence of address and data frames that open and close delivery. A design that got these wrong would deliver a phantom character, miss the framing flag, overwrite the held character, or let filtered data through.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int DATA_W = 8;
  localparam int BUS_W  = 16;

  localparam logic [2:0] REG_DATA = 3'd0;
  localparam logic [2:0] REG_DIV  = 3'd1;
  localparam logic [2:0] REG_LINE = 3'd2;
  localparam logic [2:0] REG_ADDR = 3'd3;
  localparam logic [2:0] REG_MASK = 3'd4;
  localparam logic [2:0] REG_STAT = 3'd5;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  // bit order matches the line-format register: [5] multidrop, [4:3] parity, [2] two stops, [1:0] length-5
  typedef struct packed {
    logic       nineMode;
    logic [1:0] parMode;
    logic       stop2;
    logic [1:0] lenCode;
  } lineCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxShiftIn;
    logic rxNinthCap;
    logic rxParCap;
    logic rxDone;
    logic rxBit;
  } strobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_NINTH, ST_PAR, ST_STOP
  } serState_t;

  function automatic logic parEnabled(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

  function automatic logic [DATA_W-1:0] lenMask(input logic [1:0] code);
    return {DATA_W{1'b1}} >> (2'd3 - code);
  endfunction

  function automatic logic parityBit(input logic [DATA_W-1:0] d, input logic [1:0] code,
                                     input logic [1:0] mode);
    logic p;
    p = ^(d & lenMask(code));
    return (mode == PAR_ODD) ? ~p : p;
  endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16   // oversampling ticks per bit, power of two
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  lineCfg_t         cfg,
  input  logic             txHoldFull,
  input  logic             txBit,
  input  logic             txNinth,
  input  logic             txPar,
  input  logic             rxIn,
  output strobes_t         stb,
  output logic             txOut,
  output logic             txBusy
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [DIV_W:0] divEffM1;
  logic [2:0]     lastIdx;
  logic           parOn;

  assign divEffM1 = ((divisor == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, divisor}) - 1'b1;
  assign lastIdx  = 3'd4 + {1'b0, cfg.lenCode};
  assign parOn    = parEnabled(cfg.parMode);

  // ---------------- transmitter ----------------
  serState_t      txState;
  logic [DIV_W:0] txDivCnt;
  logic [CNT_W-1:0] txCnt;
  logic [2:0]     txIdx;
  logic           txStopIdx;
  logic           txTick, txEnd, txStopLast;

  assign txTick     = (txState != ST_IDLE) && (txDivCnt == divEffM1);
  assign txEnd      = txTick && (txCnt == LAST);
  assign txStopLast = !cfg.stop2 || txStopIdx;
  assign txBusy     = (txState != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState   <= ST_IDLE;
      txDivCnt  <= '0;
      txCnt     <= '0;
      txIdx     <= '0;
      txStopIdx <= 1'b0;
    end else if (stb.txLoad) begin
      txState   <= ST_START;
      txDivCnt  <= '0;
      txCnt     <= '0;
      txIdx     <= '0;
      txStopIdx <= 1'b0;
    end else if (txState != ST_IDLE) begin
      txDivCnt <= txTick ? '0 : txDivCnt + 1'b1;
      if (txTick) txCnt <= txCnt + 1'b1;
      if (txEnd) begin
        case (txState)
          ST_START: txState <= ST_DATA;
          ST_DATA: begin
            if (txIdx == lastIdx)
              txState <= cfg.nineMode ? ST_NINTH : (parOn ? ST_PAR : ST_STOP);
            else
              txIdx <= txIdx + 1'b1;
          end
          ST_NINTH: txState <= parOn ? ST_PAR : ST_STOP;
          ST_PAR:   txState <= ST_STOP;
          ST_STOP: begin
            if (!txStopLast) txStopIdx <= 1'b1;
            else             txState   <= ST_IDLE;
          end
          default: txState <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (txState)
      ST_START: txOut = 1'b0;
      ST_DATA:  txOut = txBit;
      ST_NINTH: txOut = txNinth;
      ST_PAR:   txOut = txPar;
      default:  txOut = 1'b1;
    endcase
  end

  // ---------------- receiver ----------------
  logic rxS1, rxS2, rxPrev, rxFall;
  serState_t      rxState;
  logic [DIV_W:0] rxDivCnt;
  logic [CNT_W-1:0] rxCnt;
  logic [2:0]     rxIdx;
  logic           rxTick, rxSamp;

  assign rxFall = rxPrev && !rxS2;
  assign rxTick = (rxState != ST_IDLE) && (rxDivCnt == divEffM1);
  assign rxSamp = rxTick && (rxCnt == LAST) && (rxState != ST_START);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1   <= 1'b1;
      rxS2   <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxS1   <= rxIn;
      rxS2   <= rxS1;
      rxPrev <= rxS2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= ST_IDLE;
      rxDivCnt <= '0;
      rxCnt    <= '0;
      rxIdx    <= '0;
    end else if (rxState == ST_IDLE) begin
      if (rxFall) begin
        rxState  <= ST_START;
        rxDivCnt <= '0;
        rxCnt    <= '0;
      end
    end else begin
      rxDivCnt <= rxTick ? '0 : rxDivCnt + 1'b1;
      if (rxState == ST_START) begin
        if (rxTick) begin
          if (rxCnt == MID) begin
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxState <= rxS2 ? ST_IDLE : ST_DATA;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
      end else begin
        if (rxTick) rxCnt <= rxCnt + 1'b1;
        if (rxSamp) begin
          case (rxState)
            ST_DATA: begin
              if (rxIdx == lastIdx)
                rxState <= cfg.nineMode ? ST_NINTH : (parOn ? ST_PAR : ST_STOP);
              else
                rxIdx <= rxIdx + 1'b1;
            end
            ST_NINTH: rxState <= parOn ? ST_PAR : ST_STOP;
            ST_PAR:   rxState <= ST_STOP;
            default:  rxState <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // ---------------- strobes ----------------
  always_comb begin
    stb            = '0;
    stb.txLoad     = txHoldFull && ((txState == ST_IDLE) ||
                                    (txEnd && (txState == ST_STOP) && txStopLast));
    stb.txShift    = txEnd && (txState == ST_DATA);
    stb.rxShiftIn  = rxSamp && (rxState == ST_DATA);
    stb.rxNinthCap = rxSamp && (rxState == ST_NINTH);
    stb.rxParCap   = rxSamp && (rxState == ST_PAR);
    stb.rxDone     = rxSamp && (rxState == ST_STOP);
    stb.rxBit      = rxS2;
  end

endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  strobes_t         stb,
  input  logic             txBusy,
  output logic [DIV_W-1:0] divisor,
  output lineCfg_t         cfg,
  output logic             txHoldFull,
  output logic             rxFull,
  output logic             txBit,
  output logic             txNinth,
  output logic             txPar,
  output logic             errAny,
  output logic [2:0]       irqMask
);

  logic [DATA_W-1:0] ownAddr;
  logic wrData0, wrStat, popRx, wrTx;

  assign wrData0 = wrEn && (addr == REG_DATA);
  assign wrStat  = wrEn && (addr == REG_STAT);
  assign popRx   = rdEn && (addr == REG_DATA);
  assign wrTx    = wrData0 && !txHoldFull;

  // ---------------- configuration ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divisor <= DIV_W'(1);
      cfg     <= '{nineMode: 1'b0, parMode: 2'b00, stop2: 1'b0, lenCode: 2'b11};
      ownAddr <= '0;
      irqMask <= '0;
    end else if (wrEn) begin
      case (addr)
        REG_DIV:  divisor <= wrData[DIV_W-1:0];
        REG_LINE: cfg     <= lineCfg_t'(wrData[5:0]);
        REG_ADDR: ownAddr <= wrData[DATA_W-1:0];
        REG_MASK: irqMask <= wrData[2:0];
        default: ;
      endcase
    end
  end

  // ---------------- transmit path ----------------
  logic [DATA_W-1:0] txHold, txShiftReg;
  logic              txHoldNinth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold      <= '0;
      txHoldNinth <= 1'b0;
      txHoldFull  <= 1'b0;
      txShiftReg  <= '0;
      txNinth     <= 1'b0;
      txPar       <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txShiftReg <= txHold;
        txNinth    <= txHoldNinth;
        txPar      <= parityBit(txHold, cfg.lenCode, cfg.parMode);
        txHoldFull <= 1'b0;
      end else if (stb.txShift) begin
        txShiftReg <= txShiftReg >> 1;
      end
      if (wrTx) begin
        txHold      <= wrData[DATA_W-1:0];
        txHoldNinth <= wrData[DATA_W];
        txHoldFull  <= 1'b1;
      end
    end
  end

  assign txBit = txShiftReg[0];

  // ---------------- receive path ----------------
  logic [DATA_W-1:0] rxShiftReg, rxHold, rxData;
  logic rxNinthReg, rxParReg;
  logic parErr, frmErr, ovrErr, addrOn;
  logic isAddr, deliver, parBad;

  assign rxData  = rxShiftReg >> (2'd3 - cfg.lenCode);
  assign parBad  = parEnabled(cfg.parMode) &&
                   (rxParReg != parityBit(rxData, cfg.lenCode, cfg.parMode));
  assign isAddr  = cfg.nineMode && rxNinthReg;
  assign deliver = stb.rxDone && !isAddr && (!cfg.nineMode || addrOn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxNinthReg <= 1'b0;
      rxParReg   <= 1'b0;
      rxHold     <= '0;
      rxFull     <= 1'b0;
      addrOn     <= 1'b0;
    end else begin
      if (stb.rxShiftIn)  rxShiftReg <= {stb.rxBit, rxShiftReg[DATA_W-1:1]};
      if (stb.rxNinthCap) rxNinthReg <= stb.rxBit;
      if (stb.rxParCap)   rxParReg   <= stb.rxBit;
      if (stb.rxDone && isAddr) addrOn <= (rxData == ownAddr);
      if (deliver && (!rxFull || popRx)) begin
        rxHold <= rxData;
        rxFull <= 1'b1;
      end else if (popRx) begin
        rxFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parErr <= 1'b0;
      frmErr <= 1'b0;
      ovrErr <= 1'b0;
    end else begin
      if (stb.rxDone && parBad)           parErr <= 1'b1;
      else if (wrStat && wrData[3])       parErr <= 1'b0;
      if (stb.rxDone && !stb.rxBit)       frmErr <= 1'b1;
      else if (wrStat && wrData[4])       frmErr <= 1'b0;
      if (deliver && rxFull && !popRx)    ovrErr <= 1'b1;
      else if (wrStat && wrData[5])       ovrErr <= 1'b0;
    end
  end

  assign errAny = parErr | frmErr | ovrErr;

  // ---------------- read mux ----------------
  always_comb begin
    case (addr)
      REG_DATA: rdData = BUS_W'(rxHold);
      REG_DIV:  rdData = BUS_W'(divisor);
      REG_LINE: rdData = BUS_W'(cfg);
      REG_ADDR: rdData = BUS_W'(ownAddr);
      REG_MASK: rdData = BUS_W'(irqMask);
      REG_STAT: rdData = BUS_W'({addrOn, ovrErr, frmErr, parErr, rxFull,
                                 !txBusy && !txHoldFull, !txHoldFull});
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdu_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic        rxIn,
  output logic        txOut,
  output logic        irqTx,
  output logic        irqRx,
  output logic        irqErr
);

  strobes_t         stb;
  lineCfg_t         cfg;
  logic [DIV_W-1:0] divisor;
  logic             txHoldFull, rxFull, txBit, txNinth, txPar, txBusy, errAny;
  logic [2:0]       irqMask;

  mdu_ctrl #(.DIV_W(DIV_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .cfg(cfg),
    .txHoldFull(txHoldFull), .txBit(txBit), .txNinth(txNinth), .txPar(txPar),
    .rxIn(rxIn), .stb(stb), .txOut(txOut), .txBusy(txBusy)
  );

  mdu_dpath #(.DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .stb(stb), .txBusy(txBusy),
    .divisor(divisor), .cfg(cfg), .txHoldFull(txHoldFull), .rxFull(rxFull),
    .txBit(txBit), .txNinth(txNinth), .txPar(txPar), .errAny(errAny),
    .irqMask(irqMask)
  );

  assign irqTx  = irqMask[0] && !txHoldFull;
  assign irqRx  = irqMask[1] && rxFull;
  assign irqErr = irqMask[2] && errAny;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic [2:0] addr,
  input logic       txOut,
  input logic       txBusy,
  input logic       txHoldFull,
  input logic       rxFull,
  input strobes_t   stb
);

  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txOut);

  assert_load_needs_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |-> txHoldFull);

  assert_load_drains_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |=> !txHoldFull);

  assert_rx_fill_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(stb.rxDone));

  assert_rx_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rxShiftIn, stb.rxNinthCap, stb.rxParCap, stb.rxDone}));

  assert_rx_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !(rdEn && addr == REG_DATA)) |=> rxFull);

endmodule

bind mdrop_uart mdu_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .txOut(txOut),
  .txBusy(txBusy), .txHoldFull(txHoldFull), .rxFull(rxFull), .stb(stb)
);

// File: tb/sim_mdrop_uart.sv
`timescale 1ns/1ps
module sim_mdrop_uart;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        rxIn = 1'b1;
  logic        txOut, irqTx, irqRx, irqErr;

  int nChk = 0, nFail = 0, cycles = 0, div = 2;

  always #2 clk = ~clk;

  mdrop_uart u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
                 .wrData(wrData), .rdData(rdData), .rxIn(rxIn), .txOut(txOut),
                 .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  function automatic logic bpar(input logic [7:0] d, input int nb, input bit odd);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return odd ? ~p : p;
  endfunction

  task automatic waitIdle();
    logic [15:0] s;
    do rd(3'd5, s); while (s[1] !== 1'b1);
  endtask

  task automatic capFrame(input int nb, input bit nine, input bit par, input int stops,
                          output logic [7:0] d, output logic n9, output logic p,
                          output logic framingOk);
    d = '0; n9 = 1'b0; p = 1'b0;
    do @(negedge clk); while (txOut !== 1'b0);
    repeat (8 * div - 1) @(negedge clk);
    framingOk = (txOut === 1'b0);
    for (int i = 0; i < nb; i++) begin
      repeat (16 * div) @(negedge clk);
      d[i] = txOut;
    end
    if (nine) begin repeat (16 * div) @(negedge clk); n9 = txOut; end
    if (par)  begin repeat (16 * div) @(negedge clk); p = txOut; end
    for (int s = 0; s < stops; s++) begin
      repeat (16 * div) @(negedge clk);
      framingOk = framingOk && (txOut === 1'b1);
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit nine, input logic n9,
                           input bit par, input logic p, input logic stopLvl);
    @(negedge clk); rxIn = 1'b0;
    repeat (16 * div) @(negedge clk);
    for (int i = 0; i < nb; i++) begin rxIn = d[i]; repeat (16 * div) @(negedge clk); end
    if (nine) begin rxIn = n9; repeat (16 * div) @(negedge clk); end
    if (par)  begin rxIn = p;  repeat (16 * div) @(negedge clk); end
    rxIn = stopLvl; repeat (16 * div) @(negedge clk);
    rxIn = 1'b1;    repeat (32 * div) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    logic [15:0] s;
    chk("R1 txOut", 16'(txOut), 16'd1);
    rd(3'd5, s);
    chk("R1 status", s, 16'h0003);
    chk("R1 irqs", {13'd0, irqTx, irqRx, irqErr}, 16'd0);
    wr(3'd4, 16'h0001);
    chk("R11 irqTx when holding empty", 16'(irqTx), 16'd1);
  endtask

  task automatic tBitTime();
    int lowCnt = 0;
    div = 3;
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h0003);
    fork
      wr(3'd0, 16'h00A5);
      begin
        do @(negedge clk); while (txOut !== 1'b0);
        while (txOut === 1'b0) begin lowCnt++; @(negedge clk); end
      end
    join
    chk("R2 start bit length div=3", 16'(lowCnt), 16'd48);
    waitIdle();
    div = 2;
    wr(3'd1, 16'd2);
  endtask

  task automatic tTx8N1();
    logic [7:0] d; logic n9, p, ok;
    fork
      capFrame(8, 0, 0, 1, d, n9, p, ok);
      wr(3'd0, 16'h00A5);
    join
    chk("R3 8N1 data", 16'(d), 16'h00A5);
    chk("R3 8N1 start/stop", 16'(ok), 16'd1);
    waitIdle();
  endtask

  task automatic tTxFormats();
    logic [7:0] d; logic n9, p, ok;
    wr(3'd2, 16'h000C);               // 5 bits, 2 stops, even parity
    fork
      capFrame(5, 0, 1, 2, d, n9, p, ok);
      wr(3'd0, 16'h0013);
    join
    chk("R3 5-bit data", 16'(d), 16'h0013);
    chk("R4 even parity", 16'(p), 16'(bpar(8'h13, 5, 0)));
    chk("R3 two stop bits", 16'(ok), 16'd1);
    waitIdle();
    wr(3'd2, 16'h0012);               // 7 bits, 1 stop, odd parity
    fork
      capFrame(7, 0, 1, 1, d, n9, p, ok);
      wr(3'd0, 16'h00D5);
    join
    chk("R3 7-bit data, bit7 not sent", 16'(d), 16'h0055);
    chk("R4 odd parity", 16'(p), 16'(bpar(8'h55, 7, 1)));
    waitIdle();
    wr(3'd2, 16'h0023);               // 8 bits, multidrop
    fork
      capFrame(8, 1, 0, 1, d, n9, p, ok);
      wr(3'd0, 16'h01C3);
    join
    chk("R3 ninth bit data", 16'(d), 16'h00C3);
    chk("R3 ninth bit value", 16'(n9), 16'd1);
    waitIdle();
    wr(3'd2, 16'h0003);
  endtask

  task automatic tTxDouble();
    logic [7:0] d1, d2; logic n9, p, ok1, ok2; logic [15:0] s;
    int lows = 0;
    fork
      begin
        capFrame(8, 0, 0, 1, d1, n9, p, ok1);
        capFrame(8, 0, 0, 1, d2, n9, p, ok2);
      end
      begin
        wr(3'd0, 16'h0031);
        repeat (3) @(negedge clk);
        wr(3'd0, 16'h0032);
        wr(3'd0, 16'h0033);          // holding full: ignored
        rd(3'd5, s);
        chk("R5 holding full after queue", 16'(s[0]), 16'd0);
        chk("R11 irqTx low while holding full", 16'(irqTx), 16'd0);
      end
    join
    chk("R5 first frame", 16'(d1), 16'h0031);
    chk("R5 queued frame", 16'(d2), 16'h0032);
    waitIdle();
    repeat (16 * div * 12) begin @(negedge clk); if (txOut === 1'b0) lows++; end
    chk("R5 write to full holding ignored", 16'(lows), 16'd0);
  endtask

  task automatic tRxBasic();
    logic [15:0] s, d;
    wr(3'd4, 16'h0002);
    sendFrame(8'h5A, 8, 0, 0, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R6 rx full set", 16'(s[2]), 16'd1);
    chk("R11 irqRx", 16'(irqRx), 16'd1);
    rd(3'd0, d);
    chk("R6 rx data", d, 16'h005A);
    rd(3'd5, s);
    chk("R6 rx full cleared by read", 16'(s[2]), 16'd0);
    chk("R11 irqRx cleared", 16'(irqRx), 16'd0);
  endtask

  task automatic tRxParity();
    logic [15:0] s, d;
    wr(3'd2, 16'h0008);               // 5 bits even parity
    sendFrame(8'h15, 5, 0, 0, 1, bpar(8'h15, 5, 0), 1'b1);
    rd(3'd0, d);
    chk("R6 5-bit right aligned", d, 16'h0015);
    rd(3'd5, s);
    chk("R8 no parity error on good parity", 16'(s[3]), 16'd0);
    sendFrame(8'h15, 5, 0, 0, 1, ~bpar(8'h15, 5, 0), 1'b1);
    rd(3'd5, s);
    chk("R8 parity error flagged", 16'(s[3]), 16'd1);
    rd(3'd0, d);
    wr(3'd5, 16'h0008);
    rd(3'd5, s);
    chk("R11 parity flag cleared by write-1", 16'(s[3]), 16'd0);
    wr(3'd2, 16'h0003);
  endtask

  task automatic tRxFraming();
    logic [15:0] s, d;
    wr(3'd4, 16'h0004);
    sendFrame(8'h66, 8, 0, 0, 0, 0, 1'b0);
    rd(3'd5, s);
    chk("R8 framing error flagged", 16'(s[4]), 16'd1);
    chk("R11 irqErr raised", 16'(irqErr), 16'd1);
    rd(3'd0, d);
    wr(3'd5, 16'h0010);
    rd(3'd5, s);
    chk("R11 framing flag cleared", 16'(s[4]), 16'd0);
    chk("R11 irqErr cleared", 16'(irqErr), 16'd0);
  endtask

  task automatic tRxGlitch();
    logic [15:0] s, d;
    @(negedge clk); rxIn = 1'b0;
    repeat (4 * div) @(negedge clk);
    rxIn = 1'b1;
    repeat (16 * div * 12) @(negedge clk);
    rd(3'd5, s);
    chk("R7 glitch gives no character", 16'(s[2]), 16'd0);
    sendFrame(8'h81, 8, 0, 0, 0, 0, 1'b1);
    rd(3'd0, d);
    chk("R7 receiver still works after glitch", d, 16'h0081);
  endtask

  task automatic tOverrun();
    logic [15:0] s, d;
    sendFrame(8'h11, 8, 0, 0, 0, 0, 1'b1);
    sendFrame(8'h22, 8, 0, 0, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R9 overrun flagged", 16'(s[5]), 16'd1);
    rd(3'd0, d);
    chk("R9 held character kept", d, 16'h0011);
    wr(3'd5, 16'h0020);
    rd(3'd5, s);
    chk("R9 rx empty after read, flag cleared", {13'd0, s[5], s[2], 1'b0}, 16'd0);
  endtask

  task automatic tAddress();
    logic [15:0] s, d;
    wr(3'd2, 16'h0023);
    wr(3'd3, 16'h0042);
    sendFrame(8'h10, 8, 1, 1'b0, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R10 data dropped before address match", 16'(s[2]), 16'd0);
    sendFrame(8'h42, 8, 1, 1'b1, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R10 matching address enables, not delivered", {14'd0, s[6], s[2]}, 16'h0002);
    sendFrame(8'h11, 8, 1, 1'b0, 0, 0, 1'b1);
    rd(3'd0, d);
    chk("R10 data delivered after match", d, 16'h0011);
    sendFrame(8'h43, 8, 1, 1'b1, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R10 other address disables", {14'd0, s[6], s[2]}, 16'h0000);
    sendFrame(8'h22, 8, 1, 1'b0, 0, 0, 1'b1);
    rd(3'd5, s);
    chk("R10 data dropped after mismatch", 16'(s[2]), 16'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tBitTime();
    tTx8N1();
    tTxFormats();
    tTxDouble();
    tRxBasic();
    tRxParity();
    tRxFraming();
    tRxGlitch();
    tOverrun();
    tAddress();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule